// File: doc/BRIEF.md
# E1 Basic Frame Aligner

This block takes the recovered, already line-decoded E1 receive stream one bit at a time and finds where each 256-bit frame begins. The stream carries a fixed seven-bit alignment word in timeslot 0 of every other frame. In the frames between, timeslot 0 carries a non-alignment word whose second bit is always 1. The aligner declares basic frame synchronization only after three checks pass in order. It must see a candidate alignment word, then a 1 in bit 2 of the non-alignment word one frame later, then a correct alignment word one frame after that.

While synchronized, the block gives downstream multiframe and timeslot logic three outputs: a bit-position count tied to the frame, a flag that tells alignment frames from non-alignment frames, and a frame-start indication. The synchronization status output is active low. Alignment is dropped after a run of bad alignment words, and the search then starts again.

Top module: `e1_frame_aligner`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, syncN is 1 and bitPos, oddFrame and frameStart are 0.
- R2: A frame is 256 bits, numbered 0 to 255 in order of arrival. The alignment word is 0011011, sent first-bit-first in frame bits 1 to 7, which are bits 2 to 8 of timeslot 0. A bit is taken in only on a clock edge where rxEn is 1. A received alignment word while searching becomes the candidate.
- R3: If frame bit 1 (bit 2 of timeslot 0) of the frame after a candidate is 0, the candidate is rejected, no synchronization is declared, and the search restarts with the next bit.
- R4: If that bit is 1 and the alignment word is correct again in the frame after it, syncN goes to 0 on the edge that takes in frame bit 7 of that frame. After that edge bitPos is 8 and oddFrame is 0.
- R5: If the alignment word is wrong in the confirming frame, no synchronization is declared and the search restarts with the next bit.
- R6: While synchronized, bitPos is the frame position of the next bit to be taken in, and it wraps from 255 to 0. oddFrame is 0 for alignment-word frames and 1 for the frames between them. frameStart is 1 exactly while bitPos is 0.
- R7: While synchronized, one or two bad alignment words in a row followed by a good one keep synchronization. The third bad alignment word in a row sets syncN to 1 on the edge that takes in its frame bit 7.
- R8: While not synchronized, bitPos, oddFrame and frameStart are held at 0.
- R9: Clock cycles with rxEn at 0 change nothing, whatever value is on rxBit. This holds both during search and during sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxBit | input | 1 | Received data bit |
| rxEn | input | 1 | rxBit is valid in this cycle |
| syncN | output | 1 | 0 while basic frame synchronization is held |
| frameStart | output | 1 | Next bit is frame bit 0 (synchronized only) |
| bitPos | output | 8 | Frame position of the next bit (synchronized only) |
| oddFrame | output | 1 | 1 in non-alignment frames (synchronized only) |

## Verification
Clean frames are sent at a sweep of starting offsets, from no lead-in up to a full frame of filler. This shows that the lock point and position counter follow the stream and not reset-time state. Streams with a zero in the confirmation bit, or with a corrupted confirming alignment word, tell the three-step acceptance apart from a single-word lock. Runs of one, two and three bad alignment words during sync separate the loss threshold from an off-by-one. Idle gaps with a toggling data line, placed in the middle of an alignment word and in the middle of a synchronized frame, show that only enabled bits are counted.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH   = 2'd0,
    ST_CHK_NFAS = 2'd1,
    ST_CHK_FAS  = 2'd2,
    ST_SYNC     = 2'd3
  } alignState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPos;   // re-phase position counter onto a new candidate
    logic advance;   // step position counter by one accepted bit
  } dpStrobe_t;
endpackage

// File: rtl/e1fa_datapath.sv
module e1fa_datapath
  import e1fa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int PAT_W = 7,
  parameter logic [PAT_W-1:0] PATTERN = 7'b0011011,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxBit,
  input  logic             rxEn,
  input  dpStrobe_t        strobe,
  output logic             patMatch,
  output logic [CNT_W-1:0] nextPos,
  output logic             oddRaw
);
  localparam logic [CNT_W-1:0] LOAD_POS = CNT_W'(PAT_W + 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

  logic [PAT_W-2:0] histReg;
  logic [PAT_W-1:0] window;
  logic [CNT_W-1:0] posInc;
  logic             posWrap;

  assign window   = {histReg, rxBit};
  assign patMatch = (window == PATTERN);

  // History resets to ones so reset state cannot form part of a match
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     histReg <= '1;
    else if (rxEn) histReg <= window[PAT_W-2:0];
  end

  generate
    if ((1 << CNT_W) == FRAME_BITS) begin : g_pow2
      assign posInc = nextPos + 1'b1;
    end else begin : g_mod
      assign posInc = (nextPos == LAST_POS) ? '0 : nextPos + 1'b1;
    end
  endgenerate
  assign posWrap = (nextPos == LAST_POS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextPos <= '0;
      oddRaw  <= 1'b0;
    end else if (strobe.loadPos) begin
      nextPos <= LOAD_POS;
      oddRaw  <= 1'b0;
    end else if (strobe.advance) begin
      nextPos <= posInc;
      if (posWrap) oddRaw <= ~oddRaw;
    end
  end

  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.loadPos && nextPos == LAST_POS) |=> (nextPos == '0 && oddRaw != $past(oddRaw))) // R6
    else $error("position wrap");
  AST_LOAD_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPos |=> (nextPos == LOAD_POS && !oddRaw)) // R4
    else $error("candidate phase");
endmodule

// File: rtl/e1fa_control.sv
module e1fa_control
  import e1fa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int PAT_W = 7,
  parameter int LOSS_LIMIT = 3,
  localparam int CNT_W = $clog2(FRAME_BITS),
  localparam int MISS_W = $clog2(LOSS_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxBit,
  input  logic             rxEn,
  input  logic             patMatch,
  input  logic [CNT_W-1:0] nextPos,
  input  logic             oddRaw,
  output dpStrobe_t        strobe,
  output logic             inSync
);
  localparam logic [CNT_W-1:0] CONFIRM_POS = CNT_W'(1);
  localparam logic [CNT_W-1:0] FAS_END_POS = CNT_W'(PAT_W);
  localparam logic [MISS_W-1:0] MISS_LAST  = MISS_W'(LOSS_LIMIT - 1);

  alignState_t      state, stateNxt;
  logic [MISS_W-1:0] missCnt, missNxt;
  logic             atConfirm, atFasEnd;

  assign atConfirm = rxEn && (nextPos == CONFIRM_POS) && oddRaw;
  assign atFasEnd  = rxEn && (nextPos == FAS_END_POS) && !oddRaw;
  assign inSync    = (state == ST_SYNC);

  always_comb begin
    stateNxt       = state;
    missNxt        = missCnt;
    strobe.loadPos = 1'b0;
    unique case (state)
      ST_SEARCH: if (rxEn && patMatch) begin
        stateNxt       = ST_CHK_NFAS;
        strobe.loadPos = 1'b1;
      end
      ST_CHK_NFAS: if (atConfirm) stateNxt = rxBit ? ST_CHK_FAS : ST_SEARCH;
      ST_CHK_FAS: if (atFasEnd) begin
        stateNxt = patMatch ? ST_SYNC : ST_SEARCH;
        missNxt  = '0;
      end
      ST_SYNC: if (atFasEnd) begin
        if (patMatch) missNxt = '0;
        else if (missCnt == MISS_LAST) begin
          stateNxt = ST_SEARCH;
          missNxt  = '0;
        end else missNxt = missCnt + 1'b1;
      end
      default: stateNxt = ST_SEARCH;
    endcase
    strobe.advance = rxEn && !strobe.loadPos;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_SEARCH;
      missCnt <= '0;
    end else begin
      state   <= stateNxt;
      missCnt <= missNxt;
    end
  end

  AST_CONFIRM_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHK_NFAS && atConfirm && !rxBit) |=> state == ST_SEARCH) // R3
    else $error("confirm bit reject");
  AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inSync) |-> $past(state == ST_CHK_FAS && atFasEnd && patMatch)) // R4
    else $error("sync entry");
  AST_LOSS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inSync) |-> $past(atFasEnd && !patMatch && missCnt == MISS_LAST)) // R7
    else $error("loss threshold");
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> ($stable(state) && $stable(missCnt))) // R9
    else $error("idle cycle changed state");
endmodule

// File: rtl/e1_frame_aligner.sv
module e1_frame_aligner
  import e1fa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int LOSS_LIMIT = 3,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxBit,
  input  logic             rxEn,
  output logic             syncN,
  output logic             frameStart,
  output logic [CNT_W-1:0] bitPos,
  output logic             oddFrame
);
  dpStrobe_t        strobe;
  logic             patMatch, oddRaw, inSync;
  logic [CNT_W-1:0] nextPos;

  e1fa_datapath #(.FRAME_BITS(FRAME_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .rxEn(rxEn), .strobe(strobe),
    .patMatch(patMatch), .nextPos(nextPos), .oddRaw(oddRaw)
  );

  e1fa_control #(.FRAME_BITS(FRAME_BITS), .LOSS_LIMIT(LOSS_LIMIT)) u_ctl (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .rxEn(rxEn), .patMatch(patMatch),
    .nextPos(nextPos), .oddRaw(oddRaw), .strobe(strobe), .inSync(inSync)
  );

  assign syncN      = !inSync;
  assign bitPos     = inSync ? nextPos : '0;
  assign oddFrame   = inSync && oddRaw;
  assign frameStart = inSync && (nextPos == '0);
endmodule

// File: tb/e1_frame_aligner_test.sv
module e1_frame_aligner_test;
  localparam logic [6:0] PAT = 7'b0011011;

  logic clk = 1'b0, rstN = 1'b0, rxBit = 1'b0, rxEn = 1'b0;
  logic syncN, frameStart, oddFrame;
  logic [7:0] bitPos;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  e1_frame_aligner uut (.clk(clk), .rstN(rstN), .rxBit(rxBit), .rxEn(rxEn),
    .syncN(syncN), .frameStart(frameStart), .bitPos(bitPos), .oddFrame(oddFrame));

  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // packed view {syncN, frameStart, oddFrame, bitPos}
  function automatic int outs();
    return int'({syncN, frameStart, oddFrame, bitPos});
  endfunction

  function automatic bit frameBit(bit fas, bit bad, bit b2, int i);
    bit b = 1'b1;
    if (fas && i >= 1 && i <= 7) b = PAT[7-i];
    if (fas && bad && i == 4) b = ~b;
    if (!fas && i == 1) b = b2;
    return b;
  endfunction

  task automatic sendBit(bit b);
    rxBit = b; rxEn = 1'b1;
    @(negedge clk);
    rxEn = 1'b0;
  endtask

  // mode 0: no check, 1: unsynced quiet outputs, 2: synced tracking
  task automatic sendRange(bit fas, bit bad, bit b2, int lo, int hi, int mode, string req);
    for (int i = lo; i <= hi; i++) begin
      sendBit(frameBit(fas, bad, b2, i));
      if (mode == 1) chk(req, outs(), 11'h400);
      else if (mode == 2) begin
        int ePos = (i + 1) % 256;
        bit eOdd = (i == 255) ? fas : !fas;
        chk(req, outs(), int'({1'b0, ePos == 0, eOdd, 8'(ePos)}));
      end
    end
  endtask

  task automatic idle(int n, int expOut, string req);
    for (int k = 0; k < n; k++) begin
      rxBit = k[0]; rxEn = 1'b0;
      @(negedge clk);
      chk(req, outs(), expOut);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; rxEn = 1'b0; rxBit = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", outs(), 11'h400);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", outs(), 11'h400);
  endtask

  task automatic syncUp(int lead);
    doReset();
    for (int k = 0; k < lead; k++) begin
      sendBit(1'b1);
      chk("R8", outs(), 11'h400);
    end
    sendRange(1, 0, 0, 0, 255, 1, "R2");
    sendRange(0, 0, 1, 0, 255, 1, "R8");
    sendRange(1, 0, 0, 0, 6, 1, "R4");
    sendRange(1, 0, 0, 7, 7, 2, "R4");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int offs[10] = '{0, 1, 2, 3, 7, 8, 9, 100, 254, 255};
    @(negedge clk);
    // R2 R4 R6: lock at swept offsets, then track two frames
    foreach (offs[j]) begin
      syncUp(offs[j]);
      sendRange(1, 0, 0, 8, 255, 2, "R6");
      sendRange(0, 0, 1, 0, 255, 2, "R6");
      sendRange(1, 0, 0, 0, 255, 2, "R6");
    end
    // R3: zero confirmation bit rejects the first candidate
    doReset();
    sendRange(1, 0, 0, 0, 255, 1, "R3");
    sendRange(0, 0, 0, 0, 255, 1, "R3");
    sendRange(1, 0, 0, 0, 255, 1, "R3");
    sendRange(0, 0, 1, 0, 255, 1, "R3");
    sendRange(1, 0, 0, 0, 6, 1, "R3");
    sendRange(1, 0, 0, 7, 255, 2, "R3");
    // R5: bad confirming alignment word
    doReset();
    sendRange(1, 0, 0, 0, 255, 1, "R5");
    sendRange(0, 0, 1, 0, 255, 1, "R5");
    sendRange(1, 1, 0, 0, 255, 1, "R5");
    sendRange(0, 0, 1, 0, 255, 1, "R5");
    sendRange(1, 0, 0, 0, 255, 1, "R5");
    sendRange(0, 0, 1, 0, 255, 1, "R5");
    sendRange(1, 0, 0, 0, 6, 1, "R5");
    sendRange(1, 0, 0, 7, 255, 2, "R5");
    // R7: two misses tolerated, third drops sync
    sendRange(0, 0, 1, 0, 255, 2, "R7");
    sendRange(1, 1, 0, 0, 255, 2, "R7");
    sendRange(0, 0, 1, 0, 255, 2, "R7");
    sendRange(1, 1, 0, 0, 255, 2, "R7");
    sendRange(0, 0, 1, 0, 255, 2, "R7");
    sendRange(1, 0, 0, 0, 255, 2, "R7");
    for (int r = 0; r < 2; r++) begin
      sendRange(0, 0, 1, 0, 255, 2, "R7");
      sendRange(1, 1, 0, 0, 255, 2, "R7");
    end
    sendRange(0, 0, 1, 0, 255, 2, "R7");
    sendRange(1, 1, 0, 0, 6, 2, "R7");
    sendRange(1, 1, 0, 7, 7, 1, "R7");
    sendRange(1, 1, 0, 8, 255, 1, "R8");
    // R9: idle cycles during sync
    syncUp(4);
    sendRange(1, 0, 0, 8, 100, 2, "R9");
    idle(40, int'({1'b0, 1'b0, 1'b0, 8'd101}), "R9");
    sendRange(1, 0, 0, 101, 255, 2, "R9");
    sendRange(0, 0, 1, 0, 255, 2, "R9");
    // R9: idle cycles inside an alignment word during search
    doReset();
    sendRange(1, 0, 0, 0, 3, 1, "R9");
    idle(20, 11'h400, "R9");
    sendRange(1, 0, 0, 4, 255, 1, "R9");
    sendRange(0, 0, 1, 0, 255, 1, "R9");
    sendRange(1, 0, 0, 0, 6, 1, "R9");
    sendRange(1, 0, 0, 7, 7, 2, "R9");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule